// File: doc/BRIEF.md
# Single-Channel Pulse-Width Generator with Shadowed Timing Values

The block produces one pulse-width waveform from an up-counter that advances only on a selected clock-enable input. The counter is compared against an active period and an active duty value. The block can run edge-aligned, where the counter wraps to zero, or symmetric, where it counts up to the period and back down. From the compared waveform it derives a high-side and a complementary low-side output. Each side has its own turn-on delay, so the two switches are never driven on together.

Timing values are written through a simple write strobe with a selector. While the channel is stopped, period, duty and delay writes take effect at once. While it runs, they land in a staging copy and are transferred together at the next cycle boundary, so a waveform is never built from a mix of old and new values. A stop request lets the current cycle finish. The running flag drops on that final boundary. Every boundary reached while running raises a one-clock event pulse. The outputs are raw waveforms; any pin gating is left to the surrounding logic.

Top module: `pwm_chan`

## Requirements
- R1: After reset both outputs, the running flag and the event pulse are low, and all timing values and the mode word are zero.
- R2: The counter advances only on clock edges where the clock-enable input chosen by mode bits 9:8 is high; with that input held low, no boundary and no event pulse occur.
- R3: When mode bit 0 is 0 (edge-aligned), the counter runs 0..P and wraps to 0, giving P+1 ticks per cycle; the boundary is the wrap.
- R4: When mode bit 0 is 1 (symmetric), the counter climbs 0..P and falls back to 1, giving 2P ticks per cycle (one tick when P is 0); the boundary is the return to 0.
- R5: The compared waveform is high while the counter is below the active duty value; mode bit 1 set inverts it.
- R6: The high side follows the compared waveform and the low side follows its complement; each side output is registered, and the two undelayed sides are never both on.
- R7: With mode bit 2 set, each side's rising edge is delayed by its own count of counter ticks. The delay word carries the high-side delay in bits 15:0 and the low-side delay in bits 31:16. With bit 2 clear, both delays are zero.
- R8: A side whose delay is longer than its on-time stays off for that whole pulse.
- R9: Mode bit 3 inverts the high-side output and mode bit 4 inverts the low-side output.
- R10: While stopped, writes with selector 1 (period), 2 (duty) and 3 (delay word) change the active values at once; selector 0 writes the mode word.
- R11: While running, period, duty and delay writes are staged and all become active together at the next boundary.
- R12: A start request sets the running flag on the next clock. A stop request keeps it set until the end of the current cycle; it falls on that boundary's edge. A start request cancels a pending stop.
- R13: While running, every boundary produces a one-clock event pulse on the following clock.
- R14: Mode writes made while running are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_src | input | NSRC | Candidate counter clock enables |
| en_req | input | 1 | Start request pulse |
| dis_req | input | 1 | Stop request pulse (takes effect at cycle end) |
| wr_en | input | 1 | Write strobe |
| wr_sel | input | 2 | Write target: 0 mode, 1 period, 2 duty, 3 delay word |
| wr_data | input | 32 | Write data |
| out_hi | output | 1 | High-side output |
| out_lo | output | 1 | Low-side output |
| active | output | 1 | Running flag |
| period_irq | output | 1 | One-clock cycle-boundary event |

## Verification
A wrong counter position or direction first shows up as an output edge or an event pulse in the wrong cycle, usually within one counter cycle. A value loaded at the wrong time shows up as a changed pulse width before the boundary that should carry it. A mistimed running flag shows up as a stop that falls off a boundary or fails to follow the event pulse. The bench carries a behavioural phase model and compares all four outputs on every clock, so any such slip is reported in the cycle where it first reaches a port.

// File: rtl/pwm_chan_pkg.sv
package pwm_chan_pkg;

  localparam int WORD_W    = 32;
  localparam int DT_LO_POS = 16;

  localparam int MB_CENTER = 0;
  localparam int MB_POL    = 1;
  localparam int MB_DTEN   = 2;
  localparam int MB_INVH   = 3;
  localparam int MB_INVL   = 4;
  localparam int MB_SRC    = 8;

  typedef enum logic [1:0] {
    SEL_MODE   = 2'd0,
    SEL_PERIOD = 2'd1,
    SEL_DUTY   = 2'd2,
    SEL_DEAD   = 2'd3
  } reg_sel_e;

  typedef struct packed {
    logic inv_lo;
    logic inv_hi;
    logic dt_en;
    logic pol;
    logic center;
  } mode_flags_t;

endpackage

// File: rtl/pwm_chan_regs.sv
module pwm_chan_regs
  import pwm_chan_pkg::*;
#(
  parameter int CW = 16,
  parameter int SW = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  reg_sel_e          wr_sel,
  input  logic [WORD_W-1:0] wr_data,
  input  logic              run,
  input  logic              load,
  output logic [CW-1:0]     per_a,
  output logic [CW-1:0]     duty_a,
  output logic [CW-1:0]     dth_a,
  output logic [CW-1:0]     dtl_a,
  output mode_flags_t       flags,
  output logic [SW-1:0]     src
);

  logic [CW-1:0] per_s, duty_s, dth_s, dtl_s;
  logic [CW-1:0] per_a_n, duty_a_n, dth_a_n, dtl_a_n;
  logic [CW-1:0] per_s_n, duty_s_n, dth_s_n, dtl_s_n;
  mode_flags_t   flags_n;
  logic [SW-1:0] src_n;
  logic [CW-1:0] wd_val, wd_hi, wd_lo;
  logic          data_unused;

  assign wd_val      = wr_data[CW-1:0];
  assign wd_hi       = wr_data[CW-1:0];
  assign wd_lo       = wr_data[DT_LO_POS +: CW];
  assign data_unused = ^wr_data;

  always_comb begin
    per_a_n  = per_a;   duty_a_n = duty_a;
    dth_a_n  = dth_a;   dtl_a_n  = dtl_a;
    per_s_n  = per_s;   duty_s_n = duty_s;
    dth_s_n  = dth_s;   dtl_s_n  = dtl_s;
    flags_n  = flags;   src_n    = src;
    if (wr_en) begin
      unique case (wr_sel)
        SEL_MODE: begin
          if (!run) begin
            flags_n.center = wr_data[MB_CENTER];
            flags_n.pol    = wr_data[MB_POL];
            flags_n.dt_en  = wr_data[MB_DTEN];
            flags_n.inv_hi = wr_data[MB_INVH];
            flags_n.inv_lo = wr_data[MB_INVL];
            src_n          = wr_data[MB_SRC +: SW];
          end
        end
        SEL_PERIOD: begin
          per_s_n = wd_val;
          if (!run) per_a_n = wd_val;
        end
        SEL_DUTY: begin
          duty_s_n = wd_val;
          if (!run) duty_a_n = wd_val;
        end
        SEL_DEAD: begin
          dth_s_n = wd_hi;
          dtl_s_n = wd_lo;
          if (!run) begin
            dth_a_n = wd_hi;
            dtl_a_n = wd_lo;
          end
        end
        default: ;
      endcase
    end
    if (run && load) begin
      per_a_n  = per_s;
      duty_a_n = duty_s;
      dth_a_n  = dth_s;
      dtl_a_n  = dtl_s;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      per_a  <= '0; duty_a <= '0; dth_a <= '0; dtl_a <= '0;
      per_s  <= '0; duty_s <= '0; dth_s <= '0; dtl_s <= '0;
      flags  <= '0; src    <= '0;
    end else begin
      per_a  <= per_a_n;  duty_a <= duty_a_n;
      dth_a  <= dth_a_n;  dtl_a  <= dtl_a_n;
      per_s  <= per_s_n;  duty_s <= duty_s_n;
      dth_s  <= dth_s_n;  dtl_s  <= dtl_s_n;
      flags  <= flags_n;  src    <= src_n;
    end
  end

  logic run_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) run_q <= 1'b0;
    else        run_q <= run;
  end

  // R14: mode word holds while the channel keeps running
  assert_mode_frozen_R14: assert property (@(posedge clk) disable iff (!rst_n)
    (run && run_q) |-> ($stable(flags) && $stable(src)));

endmodule

// File: rtl/pwm_chan_timebase.sv
module pwm_chan_timebase #(
  parameter int CW   = 16,
  parameter int NSRC = 4,
  parameter int SW   = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] tick_src,
  input  logic [SW-1:0]   src,
  input  logic            center,
  input  logic [CW-1:0]   per,
  input  logic            en_req,
  input  logic            dis_req,
  output logic            tick,
  output logic            run,
  output logic [CW-1:0]   cnt,
  output logic            bnd,
  output logic            irq
);

  logic          down, dpend;
  logic          run_n, dpend_n, down_n, irq_n;
  logic [CW-1:0] cnt_n;
  logic [CW-1:0] step_cnt;
  logic          step_down, wrap;

  assign tick = tick_src[src];

  // next position of the counter on a tick
  always_comb begin
    step_cnt  = cnt;
    step_down = down;
    wrap      = 1'b0;
    if (!center) begin
      if (cnt == per) begin
        step_cnt = '0;
        wrap     = 1'b1;
      end else begin
        step_cnt = cnt + 1'b1;
      end
    end else if (per == '0) begin
      step_cnt = '0;
      wrap     = 1'b1;
    end else if (!down) begin
      if (cnt == per) begin
        step_cnt  = cnt - 1'b1;
        step_down = 1'b1;
      end else begin
        step_cnt = cnt + 1'b1;
      end
    end else begin
      step_cnt = cnt - 1'b1;
    end
    if (center && step_down && (step_cnt == '0)) begin
      wrap      = 1'b1;
      step_down = 1'b0;
    end
  end

  assign bnd = run && tick && wrap;

  always_comb begin
    run_n   = run;
    dpend_n = dpend;
    cnt_n   = cnt;
    down_n  = down;
    irq_n   = bnd;
    if (!run) begin
      dpend_n = 1'b0;
      cnt_n   = '0;
      down_n  = 1'b0;
      if (en_req) run_n = 1'b1;
    end else begin
      if (en_req)       dpend_n = 1'b0;
      else if (dis_req) dpend_n = 1'b1;
      if (bnd && dpend && !en_req) begin
        run_n   = 1'b0;
        dpend_n = 1'b0;
      end
      if (tick) begin
        cnt_n  = step_cnt;
        down_n = step_down;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run   <= 1'b0;
      dpend <= 1'b0;
      cnt   <= '0;
      down  <= 1'b0;
      irq   <= 1'b0;
    end else begin
      run   <= run_n;
      dpend <= dpend_n;
      cnt   <= cnt_n;
      down  <= down_n;
      irq   <= irq_n;
    end
  end

  // R12: the running flag only ever drops on a cycle boundary
  assert_stop_on_boundary_R12: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(run) |-> irq);

endmodule

// File: rtl/pwm_chan_deadband.sv
module pwm_chan_deadband #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          s,
  input  logic          tick,
  input  logic [CW-1:0] dt,
  output logic          q
);

  logic [CW-1:0] d, d_n;
  logic          q_n;

  always_comb begin
    d_n = d;
    q_n = q;
    if (!s) begin
      d_n = '0;
      q_n = 1'b0;
    end else if (d >= dt) begin
      q_n = 1'b1;
    end else if (tick) begin
      d_n = d + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      d <= '0;
      q <= 1'b0;
    end else begin
      d <= d_n;
      q <= q_n;
    end
  end

endmodule

// File: rtl/pwm_chan.sv
module pwm_chan
  import pwm_chan_pkg::*;
#(
  parameter int CW   = 16,
  parameter int NSRC = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NSRC-1:0]   tick_src,
  input  logic              en_req,
  input  logic              dis_req,
  input  logic              wr_en,
  input  logic [1:0]        wr_sel,
  input  logic [WORD_W-1:0] wr_data,
  output logic              out_hi,
  output logic              out_lo,
  output logic              active,
  output logic              period_irq
);

  localparam int SW     = (NSRC > 1) ? $clog2(NSRC) : 1;
  localparam int NSIDES = 2;

  logic [CW-1:0] per_a, duty_a, dth_a, dtl_a, cnt;
  mode_flags_t   flags;
  logic [SW-1:0] src;
  logic          run, bnd, tick, irq, wave;
  logic [NSIDES-1:0] side_s, side_q, side_inv;
  logic [CW-1:0]     side_dt [NSIDES];

  pwm_chan_regs #(.CW(CW), .SW(SW)) u_regs (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  (wr_en),
    .wr_sel (reg_sel_e'(wr_sel)),
    .wr_data(wr_data),
    .run    (run),
    .load   (bnd),
    .per_a  (per_a),
    .duty_a (duty_a),
    .dth_a  (dth_a),
    .dtl_a  (dtl_a),
    .flags  (flags),
    .src    (src)
  );

  pwm_chan_timebase #(.CW(CW), .NSRC(NSRC), .SW(SW)) u_tb (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick_src(tick_src),
    .src     (src),
    .center  (flags.center),
    .per     (per_a),
    .en_req  (en_req),
    .dis_req (dis_req),
    .tick    (tick),
    .run     (run),
    .cnt     (cnt),
    .bnd     (bnd),
    .irq     (irq)
  );

  assign wave      = (cnt < duty_a) ^ flags.pol;
  assign side_s[0] = run && wave;
  assign side_s[1] = run && !wave;
  assign side_dt[0] = flags.dt_en ? dth_a : '0;
  assign side_dt[1] = flags.dt_en ? dtl_a : '0;
  assign side_inv  = {flags.inv_lo, flags.inv_hi};

  for (genvar g = 0; g < NSIDES; g++) begin : g_side
    pwm_chan_deadband #(.CW(CW)) u_db (
      .clk  (clk),
      .rst_n(rst_n),
      .s    (side_s[g]),
      .tick (tick),
      .dt   (side_dt[g]),
      .q    (side_q[g])
    );
  end

  assign out_hi     = side_q[0] ^ side_inv[0];
  assign out_lo     = side_q[1] ^ side_inv[1];
  assign active     = run;
  assign period_irq = irq;

  logic run_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) run_q <= 1'b0;
    else        run_q <= run;
  end

  // R6: the two undelayed sides never conduct together
  assert_no_overlap_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !(side_q[0] && side_q[1]));

  // R3: the counter never passes the active period while running
  assert_cnt_in_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> (cnt <= per_a));

  // R11: active values change during a run only on a boundary
  assert_active_stable_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (run && run_q && !irq) |-> ($stable(per_a) && $stable(duty_a) &&
                                $stable(dth_a) && $stable(dtl_a)));

endmodule

// File: tb/pwm_chan_test.sv
`timescale 1ns/1ps
module pwm_chan_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  tick_src;
  logic        tog = 1'b0;
  logic        en_req = 1'b0, dis_req = 1'b0, wr_en = 1'b0;
  logic [1:0]  wr_sel = 2'd0;
  logic [31:0] wr_data = 32'd0;
  logic        out_hi, out_lo, active, period_irq;

  int n_tests = 0, n_fail = 0;
  string tag = "R1";
  bit done = 1'b0;

  always #5 clk = ~clk;
  always @(negedge clk) tog <= ~tog;
  assign tick_src = {1'b0, 1'b0, tog, 1'b1};

  pwm_chan uut (
    .clk(clk), .rst_n(rst_n), .tick_src(tick_src), .en_req(en_req),
    .dis_req(dis_req), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .out_hi(out_hi), .out_lo(out_lo), .active(active), .period_irq(period_irq)
  );

  // behavioural reference: phase index within the cycle
  int m_per_a, m_per_s, m_duty_a, m_duty_s, m_dh_a, m_dh_s, m_dl_a, m_dl_s;
  int m_mode, m_run, m_dp, m_p, m_qh, m_ql, m_ch, m_cl, m_irq;

  always @(posedge clk) begin
    int tk, ctr, pol, dten, len, cv, bnd, wave, sh, sl, dth, dtl;
    int n_qh, n_ql, n_ch, n_cl, n_run, n_dp, n_p;
    int a_per, a_duty, a_dh, a_dl, s_per, s_duty, s_dh, s_dl, n_mode;
    if (!rst_n) begin
      m_per_a = 0; m_per_s = 0; m_duty_a = 0; m_duty_s = 0;
      m_dh_a = 0; m_dh_s = 0; m_dl_a = 0; m_dl_s = 0;
      m_mode = 0; m_run = 0; m_dp = 0; m_p = 0;
      m_qh = 0; m_ql = 0; m_ch = 0; m_cl = 0; m_irq = 0;
    end else begin
      tk   = int'(tick_src[(m_mode >> 8) & 3]);
      ctr  = m_mode & 1;
      pol  = (m_mode >> 1) & 1;
      dten = (m_mode >> 2) & 1;
      len  = ctr ? ((m_per_a == 0) ? 1 : 2 * m_per_a) : m_per_a + 1;
      cv   = (ctr && m_p > m_per_a) ? 2 * m_per_a - m_p : m_p;
      bnd  = (m_run && tk && (m_p == len - 1)) ? 1 : 0;
      wave = ((cv < m_duty_a) ? 1 : 0) ^ pol;
      sh   = (m_run && wave) ? 1 : 0;
      sl   = (m_run && !wave) ? 1 : 0;
      dth  = dten ? m_dh_a : 0;
      dtl  = dten ? m_dl_a : 0;
      n_ch = m_ch; n_qh = m_qh;
      if (!sh) begin n_ch = 0; n_qh = 0; end
      else if (m_ch >= dth) n_qh = 1;
      else if (tk) n_ch = m_ch + 1;
      n_cl = m_cl; n_ql = m_ql;
      if (!sl) begin n_cl = 0; n_ql = 0; end
      else if (m_cl >= dtl) n_ql = 1;
      else if (tk) n_cl = m_cl + 1;
      a_per = m_per_a; a_duty = m_duty_a; a_dh = m_dh_a; a_dl = m_dl_a;
      s_per = m_per_s; s_duty = m_duty_s; s_dh = m_dh_s; s_dl = m_dl_s;
      n_mode = m_mode;
      if (wr_en) begin
        case (wr_sel)
          2'd0: if (!m_run) n_mode = int'(wr_data & 32'h31F);
          2'd1: begin s_per = int'(wr_data[15:0]); if (!m_run) a_per = s_per; end
          2'd2: begin s_duty = int'(wr_data[15:0]); if (!m_run) a_duty = s_duty; end
          default: begin
            s_dh = int'(wr_data[15:0]); s_dl = int'(wr_data[31:16]);
            if (!m_run) begin a_dh = s_dh; a_dl = s_dl; end
          end
        endcase
      end
      if (bnd) begin
        a_per = m_per_s; a_duty = m_duty_s; a_dh = m_dh_s; a_dl = m_dl_s;
      end
      n_run = m_run; n_dp = m_dp;
      if (!m_run) begin n_dp = 0; if (en_req) n_run = 1; end
      else begin
        if (en_req) n_dp = 0; else if (dis_req) n_dp = 1;
        if (bnd && m_dp && !en_req) begin n_run = 0; n_dp = 0; end
      end
      if (!m_run) n_p = 0;
      else if (tk) n_p = (m_p == len - 1) ? 0 : m_p + 1;
      else n_p = m_p;
      m_per_a = a_per; m_duty_a = a_duty; m_dh_a = a_dh; m_dl_a = a_dl;
      m_per_s = s_per; m_duty_s = s_duty; m_dh_s = s_dh; m_dl_s = s_dl;
      m_mode = n_mode; m_run = n_run; m_dp = n_dp; m_p = n_p;
      m_qh = n_qh; m_ql = n_ql; m_ch = n_ch; m_cl = n_cl; m_irq = bnd;
    end
  end

  task automatic check(input string req, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  // per-clock comparison against the reference
  always @(negedge clk) begin
    if (rst_n && !done) begin
      n_tests++;
      if (out_hi !== 1'(m_qh ^ ((m_mode >> 3) & 1)) ||
          out_lo !== 1'(m_ql ^ ((m_mode >> 4) & 1)) ||
          active !== 1'(m_run) || period_irq !== 1'(m_irq)) begin
        n_fail++;
        $display("FAIL %s: actual hi%0d lo%0d run%0d irq%0d expected hi%0d lo%0d run%0d irq%0d at %0t",
                 tag, out_hi, out_lo, active, period_irq,
                 m_qh ^ ((m_mode >> 3) & 1), m_ql ^ ((m_mode >> 4) & 1), m_run, m_irq, $time);
      end
    end
  end

  task automatic wreg(input logic [1:0] s, input logic [31:0] d);
    wr_en = 1'b1; wr_sel = s; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic start();
    en_req = 1'b1; @(negedge clk); en_req = 1'b0;
  endtask

  task automatic stop_and_wait(input string req);
    int seen_irq;
    dis_req = 1'b1; @(negedge clk); dis_req = 1'b0;
    check(req, int'(active), 1);
    seen_irq = 0;
    for (int i = 0; i < 200; i++) begin
      if (!active) break;
      seen_irq = int'(period_irq);
      @(negedge clk);
    end
    check(req, int'(active), 0);
    check(req, int'(period_irq), 1);
  endtask

  task automatic count_irq(input int cycles, output int c);
    c = 0;
    for (int i = 0; i < cycles; i++) begin
      @(negedge clk);
      if (period_irq) c++;
    end
  endtask

  initial begin
    int c, hi_ones;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    tag = "R1";
    check("R1", int'(out_hi), 0);
    check("R1", int'(out_lo), 0);
    check("R1", int'(active), 0);
    check("R1", int'(period_irq), 0);

    // edge-aligned, every-clock tick, both delays on
    tag = "R10/R3/R6/R7";
    wreg(2'd0, 32'h0000_0004);
    wreg(2'd1, 32'd9);
    wreg(2'd2, 32'd4);
    wreg(2'd3, (32'd2 << 16) | 32'd1);
    start();
    check("R12", int'(active), 1);
    repeat (5) @(negedge clk);
    count_irq(50, c);
    check("R3", c, 5);

    // staged values while running
    tag = "R11";
    wreg(2'd2, 32'd3);
    wreg(2'd1, 32'd5);
    repeat (30) @(negedge clk);
    count_irq(36, c);
    check("R11", c, 6);

    // mode change while running is dropped
    tag = "R14";
    wreg(2'd0, 32'h0000_0018);
    repeat (12) @(negedge clk);

    tag = "R12";
    stop_and_wait("R12");

    // symmetric, half-rate tick, high-side delay longer than its pulse
    tag = "R4/R8/R9/R10";
    wreg(2'd0, 32'h0000_010D);
    wreg(2'd1, 32'd6);
    wreg(2'd2, 32'd3);
    wreg(2'd3, (32'd2 << 16) | 32'd6);
    start();
    repeat (4) @(negedge clk);
    hi_ones = 0;
    for (int i = 0; i < 48; i++) begin
      @(negedge clk);
      if (out_hi) hi_ones++;
    end
    check("R8", hi_ones, 48);
    count_irq(48, c);
    check("R4", c, 2);
    tag = "R12";
    stop_and_wait("R12");

    // inverted polarity, zero period: boundary on every tick
    tag = "R5/R13";
    wreg(2'd0, 32'h0000_0002);
    wreg(2'd1, 32'd0);
    wreg(2'd2, 32'd0);
    start();
    repeat (2) @(negedge clk);
    check("R5", int'(out_hi), 1);
    check("R5", int'(out_lo), 0);
    count_irq(20, c);
    check("R13", c, 20);
    tag = "R12";
    stop_and_wait("R12");

    // idle clock source: nothing advances
    tag = "R2";
    wreg(2'd0, 32'h0000_0200);
    wreg(2'd1, 32'd3);
    wreg(2'd2, 32'd1);
    start();
    count_irq(20, c);
    check("R2", c, 0);
    check("R2", int'(active), 1);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #200000;
    if (!done) begin
      done = 1'b1;
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

endmodule